// File: doc/BRIEF.md
# Serial Configuration Memory Read Port

This block is the read side of a one-time-programmable serial memory that boots an SRAM-based FPGA. The image is a set of 32-bit words. The memory sends the image one bit per rising clock edge while it is selected and its output is enabled. A single control pin does two jobs. In one level it clears the position counters. In the other level it enables the data driver. A stored polarity word, held just past the last image word, selects which pin level clears the counters.

When the last bit of the image has gone out, the block releases its data line and drives its chain-select output low. That output feeds the select input of the next memory, so several memories in a daisy chain produce one unbroken bitstream. The image content is computed from a seed parameter, which lets a chain of instances carry distinct images.

The block has two named states. STREAM covers reset and counting through the image. HANDOFF is entered from STREAM on the clock edge after the last bit has been read. HANDOFF stays in force, with the counters frozen, until the clear function takes the block back to STREAM. Nothing else leaves HANDOFF.

Top module: `serial_cfg_rom`

## Requirements
- R1: While the clear function of `gate_rst` is asserted, both position counters are asynchronously zero and the state is STREAM, so `sel_out_n` is 1 and `dout_en` is 0. A clear pulse in the middle of the image makes the next visible bit bit 0 of word 0.
- R2: Word `a` (0 <= a < DEPTH) holds `SEED ^ (a * 32'h9E3779B1)`, taken modulo 2^32. Bits go out LSB first, and the word address steps after bit 31. Every rising edge with `sel_n` low in STREAM advances one bit, so the n-th visible bit since clear is bit n%32 of word n/32.
- R3: `dout_en` is 1 only when `sel_n` is low, the enable function of `gate_rst` is active, and the state is STREAM. `dout` is 0 whenever `dout_en` is 0.
- R4: While `sel_n` is high, the counters are frozen and `dout_en` is 0. After `sel_n` returns low, the stream resumes at the bit that was showing before.
- R5: On the rising edge after the last bit (word DEPTH-1, bit 31) has been presented with `sel_n` low, the state becomes HANDOFF, `dout_en` drops to 0 and `sel_out_n` goes low.
- R6: In STREAM, `sel_out_n` is 1. In HANDOFF, `sel_out_n` equals `sel_n` while the enable function is active. When the clear function is asserted, `sel_out_n` is 1, and it stays 1 until the image has been read to its end again.
- R7: In HANDOFF, further clocks neither wrap nor move the counters. No data is driven again until a clear.
- R8: If POL_WORD is all zeros, `gate_rst` low clears and `gate_rst` high enables. For any other value, including the all-ones default, `gate_rst` high clears and `gate_rst` low enables.
- R9: Two instances chained `sel_out_n` to `sel_n`, with a shared `gate_rst`, deliver the first image and then the second with no idle cycle between them. At most one `dout_en` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; rising edge advances the bit position |
| sel_n | input | 1 | Active-low device select; high freezes counters (standby) |
| gate_rst | input | 1 | Combined clear / output-enable pin, meaning set by POL_WORD |
| dout | output | 1 | Current image bit, 0 when not driven |
| dout_en | output | 1 | Output driver enable for `dout` (0 means high impedance) |
| sel_out_n | output | 1 | Active-low select passed to the next memory in the chain |

## Verification
A wrong bit or word counter shows up on `dout` at the first visible bit after the fault, because each position appears for exactly one cycle and is compared against the seeded image formula. A counter that moves during standby makes the resumed bit mismatch on the first cycle after `sel_n` returns low. A wrong state or terminal decision shows up as one of three faults: `sel_out_n` dropping early, contention on the shared chain bus, or a gap or extra bit at the handoff into the second device. Each of these appears within one clock of the faulty edge. A polarity error makes the low-polarity instance drive while it should be clearing, which is visible on the first sample.

// File: rtl/cfg_rom_pkg.sv
package cfg_rom_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned BIT_W  = $clog2(WORD_W);

    typedef enum logic [0:0] {
        ST_STREAM  = 1'b0,
        ST_HANDOFF = 1'b1
    } seq_state_t;

    // Image content: seed mixed with a multiplicative hash of the address.
    function automatic logic [WORD_W-1:0] image_word(input logic [31:0] seed,
                                                      input logic [31:0] addr);
        logic [31:0] mix;
        mix = addr * 32'h9E3779B1;
        return seed ^ mix;
    endfunction
endpackage

// File: rtl/cfg_pos_counter.sv
module cfg_pos_counter
    import cfg_rom_pkg::*;
#(
    parameter int unsigned DEPTH = 1134
) (
    input  logic                       clk,
    input  logic                       clr,
    input  logic                       step,
    output logic [BIT_W-1:0]           bit_idx,
    output logic [$clog2(DEPTH)-1:0]   word_addr,
    output logic                       at_last
);
    localparam int unsigned ADDR_W = $clog2(DEPTH);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);
    localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(WORD_W - 1);

    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            bit_idx   <= '0;
            word_addr <= '0;
        end else if (step) begin
            if (bit_idx == LAST_BIT) begin
                bit_idx   <= '0;
                word_addr <= word_addr + 1'b1;
            end else begin
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end

    assign at_last = (word_addr == LAST_ADDR) && (bit_idx == LAST_BIT);
endmodule

// File: rtl/cfg_image_rom.sv
module cfg_image_rom
    import cfg_rom_pkg::*;
#(
    parameter int unsigned DEPTH = 1134,
    parameter logic [31:0] SEED  = 32'h0
) (
    input  logic [$clog2(DEPTH)-1:0] word_addr,
    input  logic [BIT_W-1:0]         bit_idx,
    output logic                     bit_val
);
    logic [WORD_W-1:0] word_q;

    always_comb begin
        word_q  = image_word(SEED, 32'(word_addr));
        bit_val = word_q[bit_idx];
    end
endmodule

// File: rtl/cfg_seq_fsm.sv
module cfg_seq_fsm
    import cfg_rom_pkg::*;
(
    input  logic       clk,
    input  logic       clr,
    input  logic       sel_n,
    input  logic       at_last,
    output seq_state_t state,
    output logic       cnt_step,
    output logic       drive_en,
    output logic       chain_n
);
    seq_state_t state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_STREAM:  if (!sel_n && at_last) state_nx = ST_HANDOFF;
            ST_HANDOFF: state_nx = ST_HANDOFF;
            default:    state_nx = ST_STREAM;
        endcase
    end

    always_ff @(posedge clk or posedge clr) begin
        if (clr) state <= ST_STREAM;
        else     state <= state_nx;
    end

    // Output process: clr low means the enable function is active.
    always_comb begin
        cnt_step = 1'b0;
        drive_en = 1'b0;
        chain_n  = 1'b1;
        unique case (state)
            ST_STREAM: begin
                cnt_step = !sel_n && !at_last;
                drive_en = !sel_n && !clr;
            end
            ST_HANDOFF: begin
                chain_n = sel_n || clr;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/serial_cfg_rom.sv
module serial_cfg_rom
    import cfg_rom_pkg::*;
#(
    parameter int unsigned DEPTH    = 1134,
    parameter logic [31:0] SEED     = 32'h5A5A_0F0F,
    parameter logic [31:0] POL_WORD = 32'hFFFF_FFFF
) (
    input  logic clk,
    input  logic sel_n,
    input  logic gate_rst,
    output logic dout,
    output logic dout_en,
    output logic sel_out_n
);
    localparam int unsigned ADDR_W = $clog2(DEPTH);

    logic               clr;
    logic               cnt_step;
    logic               drive_en;
    logic               at_last;
    logic               bit_val;
    logic [BIT_W-1:0]   bit_idx;
    logic [ADDR_W-1:0]  word_addr;
    seq_state_t         state;

    // Polarity word chooses which pin level clears the counters.
    generate
        if (POL_WORD == 32'h0) begin : g_clr_low
            assign clr = !gate_rst;
        end else begin : g_clr_high
            assign clr = gate_rst;
        end
    endgenerate

    cfg_pos_counter #(.DEPTH(DEPTH)) u_pos (
        .clk       (clk),
        .clr       (clr),
        .step      (cnt_step),
        .bit_idx   (bit_idx),
        .word_addr (word_addr),
        .at_last   (at_last)
    );

    cfg_image_rom #(.DEPTH(DEPTH), .SEED(SEED)) u_img (
        .word_addr (word_addr),
        .bit_idx   (bit_idx),
        .bit_val   (bit_val)
    );

    cfg_seq_fsm u_seq (
        .clk      (clk),
        .clr      (clr),
        .sel_n    (sel_n),
        .at_last  (at_last),
        .state    (state),
        .cnt_step (cnt_step),
        .drive_en (drive_en),
        .chain_n  (sel_out_n)
    );

    assign dout_en = drive_en;
    assign dout    = drive_en & bit_val;
endmodule

// File: rtl/cfg_rom_checker.sv
module cfg_rom_checker
    import cfg_rom_pkg::*;
#(
    parameter int unsigned DEPTH    = 1134,
    parameter logic [31:0] POL_WORD = 32'hFFFF_FFFF
) (
    input logic                     clk,
    input logic                     sel_n,
    input logic                     gate_rst,
    input logic                     dout,
    input logic                     dout_en,
    input logic                     sel_out_n,
    input seq_state_t               state,
    input logic [BIT_W-1:0]         bit_idx,
    input logic [$clog2(DEPTH)-1:0] word_addr,
    input logic                     at_last
);
    logic chk_clr;
    assign chk_clr = (POL_WORD == 32'h0) ? !gate_rst : gate_rst;

    // R2: one bit per enabled edge, address steps after bit 31
    p_step_r2: assert property (@(posedge clk) disable iff (chk_clr)
        (!sel_n && state == ST_STREAM && !at_last) |=>
        (bit_idx == (($past(bit_idx) == BIT_W'(WORD_W - 1)) ? '0 : $past(bit_idx) + 1'b1)));

    // R3: driver only when selected and enabled
    p_gate_r3: assert property (@(posedge clk) disable iff (chk_clr)
        dout_en |-> !sel_n);

    // R3: released line reads zero
    p_quiet_r3: assert property (@(posedge clk) disable iff (chk_clr)
        !dout_en |-> !dout);

    // R4: standby freezes position
    p_freeze_r4: assert property (@(posedge clk) disable iff (chk_clr)
        sel_n |=> ($stable(bit_idx) && $stable(word_addr)));

    // R5: handoff after last bit
    p_handoff_r5: assert property (@(posedge clk) disable iff (chk_clr)
        (state == ST_STREAM && !sel_n && at_last) |=> (state == ST_HANDOFF && !dout_en));

    // R6: chain select idle while streaming
    p_chain_idle_r6: assert property (@(posedge clk) disable iff (chk_clr)
        (state == ST_STREAM) |-> sel_out_n);

    // R7: no wrap at end of image
    p_hold_r7: assert property (@(posedge clk) disable iff (chk_clr)
        (state == ST_HANDOFF) |=> (state == ST_HANDOFF && $stable(word_addr) && $stable(bit_idx)));
endmodule

bind serial_cfg_rom cfg_rom_checker #(.DEPTH(DEPTH), .POL_WORD(POL_WORD)) u_chk (
    .clk       (clk),
    .sel_n     (sel_n),
    .gate_rst  (gate_rst),
    .dout      (dout),
    .dout_en   (dout_en),
    .sel_out_n (sel_out_n),
    .state     (state),
    .bit_idx   (bit_idx),
    .word_addr (word_addr),
    .at_last   (at_last)
);

// File: tb/serial_cfg_rom_test.sv
module serial_cfg_rom_test;
    localparam int CLK_PERIOD = 10;
    localparam int DA = 3;
    localparam int DB = 2;
    localparam int DL = 2;
    localparam logic [31:0] SA = 32'h1234_ABCD;
    localparam logic [31:0] SB = 32'hC0DE_0077;
    localparam logic [31:0] SL = 32'h0F0F_3C3C;

    logic clk = 1'b0;
    logic gate = 1'b1;
    logic sel_a = 1'b0;
    logic sel_l = 1'b1;
    logic pin_l = 1'b0;
    logic dout_a, en_a, out_a;
    logic dout_b, en_b, out_b;
    logic dout_l, en_l, out_l;
    logic mon_en = 1'b0;
    int   checks = 0;
    int   errors = 0;
    int   popped = 0;
    logic exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_cfg_rom #(.DEPTH(DA), .SEED(SA)) uut (
        .clk(clk), .sel_n(sel_a), .gate_rst(gate),
        .dout(dout_a), .dout_en(en_a), .sel_out_n(out_a));

    serial_cfg_rom #(.DEPTH(DB), .SEED(SB)) u_next (
        .clk(clk), .sel_n(out_a), .gate_rst(gate),
        .dout(dout_b), .dout_en(en_b), .sel_out_n(out_b));

    serial_cfg_rom #(.DEPTH(DL), .SEED(SL), .POL_WORD(32'h0)) u_lowpol (
        .clk(clk), .sel_n(sel_l), .gate_rst(pin_l),
        .dout(dout_l), .dout_en(en_l), .sel_out_n(out_l));

    function automatic logic [31:0] ref_word(input logic [31:0] s, input int unsigned a);
        logic [31:0] h;
        h = a * 32'h9E3779B1;
        return s ^ h;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic drive_edge();
        @(posedge clk);
        #2;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Scoreboard monitor for the chained bus (R2, R4, R5, R9)
    always @(negedge clk) begin
        if (mon_en) begin
            if (en_a && en_b) begin
                checks++; errors++;
                $display("FAIL R9: actual both drivers on expected one at %0t", $time);
            end else if (en_a || en_b) begin
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R7: actual extra bit expected released at %0t", $time);
                end else begin
                    logic e;
                    e = exp_q.pop_front();
                    if (popped == DA * 32) begin
                        check("R5 handoff sel_out_n", {31'd0, out_a}, 32'd0);
                        check("R5 first device released", {31'd0, en_a}, 32'd0);
                    end
                    popped++;
                    check("R2/R9 stream bit", {31'd0, en_a ? dout_a : dout_b}, {31'd0, e});
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset dout_en", {31'd0, en_a}, 32'd0);
        check("R1 reset sel_out_n", {31'd0, out_a}, 32'd1);
        check("R3 reset dout low", {31'd0, dout_a}, 32'd0);
        check("R8 low polarity held in clear", {31'd0, en_l}, 32'd0);

        for (int a = 0; a < DA; a++)
            for (int b = 0; b < 32; b++) exp_q.push_back(ref_word(SA, a)[b]);
        for (int a = 0; a < DB; a++)
            for (int b = 0; b < 32; b++) exp_q.push_back(ref_word(SB, a)[b]);

        drive_edge();
        gate = 1'b0;
        mon_en = 1'b1;
        repeat (40) @(posedge clk);
        #2 sel_a = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R4 standby released", {31'd0, en_a}, 32'd0);
        check("R4 standby chain idle", {31'd0, out_a}, 32'd1);
        drive_edge();
        sel_a = 1'b0;

        for (int i = 0; i < 400 && popped < (DA + DB) * 32; i++) @(posedge clk);
        @(negedge clk);
        check("R9 all bits delivered", popped, (DA + DB) * 32);
        check("R5 second device sel_out_n", {31'd0, out_b}, 32'd0);
        check("R5 second device released", {31'd0, en_b}, 32'd0);

        repeat (40) @(posedge clk);
        @(negedge clk);
        check("R7 hold after end", {31'd0, out_b}, 32'd0);
        check("R7 no rewrap first", {31'd0, en_a}, 32'd0);

        drive_edge(); sel_a = 1'b1;
        @(negedge clk);
        check("R6 follows sel high", {31'd0, out_a}, 32'd1);
        drive_edge(); sel_a = 1'b0;
        @(negedge clk);
        check("R6 follows sel low", {31'd0, out_a}, 32'd0);

        drive_edge(); mon_en = 1'b0; gate = 1'b1;
        @(negedge clk);
        check("R6 clear raises sel_out_n", {31'd0, out_a}, 32'd1);
        check("R1 clear releases data", {31'd0, en_a}, 32'd0);
        drive_edge(); gate = 1'b0;
        @(negedge clk);
        check("R1 restart bit0", {31'd0, dout_a}, {31'd0, ref_word(SA, 0)[0]});
        check("R6 stays high on re-read", {31'd0, out_a}, 32'd1);
        repeat (37) @(posedge clk);
        @(negedge clk);
        check("R2 bit 37 = word1 bit5", {31'd0, dout_a}, {31'd0, ref_word(SA, 1)[5]});
        drive_edge(); gate = 1'b1;
        drive_edge(); gate = 1'b0;
        @(negedge clk);
        check("R1 mid-stream clear bit0", {31'd0, dout_a}, {31'd0, ref_word(SA, 0)[0]});
        check("R3 enabled", {31'd0, en_a}, 32'd1);
        drive_edge(); sel_a = 1'b1;

        // Low polarity instance (R8)
        drive_edge(); sel_l = 1'b0;
        @(negedge clk);
        check("R8 low pin clears", {31'd0, en_l}, 32'd0);
        drive_edge(); pin_l = 1'b1;
        @(negedge clk);
        check("R8 high pin enables", {31'd0, en_l}, 32'd1);
        check("R8 bit0", {31'd0, dout_l}, {31'd0, ref_word(SL, 0)[0]});
        repeat (33) @(posedge clk);
        @(negedge clk);
        check("R8 bit33", {31'd0, dout_l}, {31'd0, ref_word(SL, 1)[1]});
        drive_edge(); pin_l = 1'b0;
        @(negedge clk);
        check("R8 low pin releases", {31'd0, en_l}, 32'd0);
        drive_edge(); pin_l = 1'b1;
        @(negedge clk);
        check("R8 restart bit0", {31'd0, dout_l}, {31'd0, ref_word(SL, 0)[0]});
        drive_edge(); sel_l = 1'b1;
        @(negedge clk);
        check("R3 deselect releases", {31'd0, en_l}, 32'd0);

        finish_run();
    end
endmodule